// File: doc/BRIEF.md
# Debug Cross-Trigger Interface

This block sits beside one processor and moves debug trigger events between that processor (plus its trace logic) and a shared channel fabric. Each input trigger can be forwarded onto any set of channels through a per-trigger input map. Each output trigger is raised from any set of channels through a per-trigger output map. The channels seen by the output side are the union of the channels arriving from the fabric and the channels this block is raising itself.

A small register port holds the maps, a control word, a write-one acknowledge word and a software channel-pulse word. It also gives live views of the input triggers and the incoming channels, and an identity word with the configured sizes.

The low output triggers have fixed roles, each with its own removal rule:
- 0 is a halt request that stays up until acknowledged.
- 1 is a restart request that is only delivered to a halted core and is never remembered.
- 2 is an interrupt that is either a pulse or an acknowledged level.
- 3 is reserved.
- 4 and up are self-clearing events.

Top module: `xtrig_iface`

## Requirements
- R1: After reset every output trigger and every output channel is low, the control word (address 0) reads 0, and all input and output maps read 0.
- R2: While the enable bit (address 0, bit 0) is set, output channel c is high in the cycle after a cycle in which some input trigger i was high with bit c of its input map (address 32+i) set, and low otherwise.
- R3: A write to address 2 with bit c set (c below the channel count) raises output channel c for exactly one cycle, starting the cycle after the write. In the write cycle it also acts as a channel event for the output maps.
- R4: Output trigger j for j of 4 and above is high in the cycle after a channel event on any channel selected by its output map (address 64+j). A channel event is an incoming channel or a channel this block raises. The output is low after a cycle with no such event.
- R5: Output trigger 0 rises after a mapped channel event and stays high, whatever the core-halted input does, until a write to address 1 with bit 0 set. If a new event falls in the same cycle as that acknowledge, the output stays high.
- R6: Output trigger 1 is high in the cycle after a mapped channel event only if core_halted was high in that same cycle. An event seen while the core runs is discarded and never delivered later.
- R7: With control bit 1 clear (the reset value), output trigger 2 follows mapped channel events as a pulse. With it set, output trigger 2 holds after an event until a write to address 1 with bit 2 set.
- R8: Output trigger 3 is always low, whatever its output map holds.
- R9: While the enable bit is clear, no output channel rises and no output trigger newly rises, but the status words still track the inputs.
- R10: Address 3 reads the live input triggers and address 4 reads the live incoming channels, in the same cycle, whatever the enable bit.
- R11: Address 5 reads the channel count in bits [5:0] and the trigger count in bits [13:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_TRIG | Trigger events from the processor and trace logic |
| core_halted | input | 1 | High while the processor is in its halted debug state |
| ch_in | input | NUM_CH | Channel events arriving from the fabric |
| trig_out | output | NUM_TRIG | Trigger events to the processor, trace logic and interrupt controller |
| ch_out | output | NUM_CH | Channel events driven into the fabric |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |

## Verification
The sharpest overlap is a software acknowledge of the halt request or of the level interrupt arriving in the same cycle as a fresh mapped event for that output. The bench forces this directly for the halt output, and the random phase produces it for both outputs by mixing acknowledge writes with dense input traffic. A second overlap is a software channel pulse in the same cycle as live input triggers on other channels. Every cycle is judged against a bench model built from the requirements, which merges both sources and lets the new event win over the acknowledge.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  localparam int REG_AW = 7;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] RA_CTRL   = 7'd0;
  localparam logic [REG_AW-1:0] RA_ACK    = 7'd1;
  localparam logic [REG_AW-1:0] RA_APP    = 7'd2;
  localparam logic [REG_AW-1:0] RA_TSTAT  = 7'd3;
  localparam logic [REG_AW-1:0] RA_CSTAT  = 7'd4;
  localparam logic [REG_AW-1:0] RA_ID     = 7'd5;
  localparam logic [REG_AW-1:0] RA_INMAP  = 7'd32;
  localparam logic [REG_AW-1:0] RA_OUTMAP = 7'd64;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_LVL_BIT = 1;
  localparam int ACK_HALT_BIT = 0;
  localparam int ACK_IRQ_BIT  = 2;

  typedef enum logic [2:0] {
    TK_HALT,
    TK_RESTART,
    TK_IRQ,
    TK_RESERVED,
    TK_SELFCLR
  } trig_kind_e;

  typedef struct packed {
    logic irq_level;
    logic en;
  } ctrl_t;

  // Role of each output trigger slot; slots past the architected set self-clear.
  function automatic trig_kind_e trig_kind(input int idx);
    case (idx)
      0:       return TK_HALT;
      1:       return TK_RESTART;
      2:       return TK_IRQ;
      3:       return TK_RESERVED;
      default: return TK_SELFCLR;
    endcase
  endfunction

endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CH   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [REG_AW-1:0]                wr_addr,
  input  logic [REG_DW-1:0]                wr_data,
  input  logic [REG_AW-1:0]                rd_addr,
  output logic [REG_DW-1:0]                rd_data,
  input  logic [NUM_TRIG-1:0]              trig_live,
  input  logic [NUM_CH-1:0]                ch_live,
  output ctrl_t                            ctrl,
  output logic                             ack_halt,
  output logic                             ack_irq,
  output logic [NUM_CH-1:0]                app_pulse,
  output logic [NUM_TRIG-1:0][NUM_CH-1:0]  in_map,
  output logic [NUM_TRIG-1:0][NUM_CH-1:0]  out_map
);

  localparam int ID_W = 6;

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_we;
  logic  ack_sel;
  logic  app_sel;
  logic  unused_wr_data;

  assign ctrl_we  = wr_en && (wr_addr == RA_CTRL);
  assign ack_sel  = wr_en && (wr_addr == RA_ACK);
  assign app_sel  = wr_en && (wr_addr == RA_APP);

  assign ack_halt  = ack_sel && wr_data[ACK_HALT_BIT];
  assign ack_irq   = ack_sel && wr_data[ACK_IRQ_BIT];
  assign app_pulse = app_sel ? wr_data[NUM_CH-1:0] : '0;
  assign unused_wr_data = ^wr_data;

  // Control word next state
  always_comb begin
    ctrl_d           = ctrl_q;
    ctrl_d.en        = wr_data[CTRL_EN_BIT];
    ctrl_d.irq_level = wr_data[CTRL_LVL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  // One input-map row and one output-map row per trigger
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_row
    logic              in_we;
    logic              out_we;
    logic [NUM_CH-1:0] in_q;
    logic [NUM_CH-1:0] out_q;
    logic [NUM_CH-1:0] row_d;

    assign in_we  = wr_en && (wr_addr == REG_AW'(int'(RA_INMAP) + t));
    assign out_we = wr_en && (wr_addr == REG_AW'(int'(RA_OUTMAP) + t));
    assign row_d  = wr_data[NUM_CH-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q <= '0;
      end else if (in_we) begin
        in_q <= row_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
      end else if (out_we) begin
        out_q <= row_d;
      end
    end

    assign in_map[t]  = in_q;
    assign out_map[t] = out_q;
  end

  // Read multiplexer
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[CTRL_EN_BIT]  = ctrl_q.en;
        rd_data[CTRL_LVL_BIT] = ctrl_q.irq_level;
      end
      RA_TSTAT: rd_data[NUM_TRIG-1:0] = trig_live;
      RA_CSTAT: rd_data[NUM_CH-1:0]   = ch_live;
      RA_ID: begin
        rd_data[ID_W-1:0]   = ID_W'(NUM_CH);
        rd_data[ID_W+7:8]   = ID_W'(NUM_TRIG);
      end
      default: ;
    endcase
    for (int t = 0; t < NUM_TRIG; t++) begin
      if (rd_addr == REG_AW'(int'(RA_INMAP) + t)) begin
        rd_data[NUM_CH-1:0] = in_map[t];
      end
      if (rd_addr == REG_AW'(int'(RA_OUTMAP) + t)) begin
        rd_data[NUM_CH-1:0] = out_map[t];
      end
    end
  end

endmodule

// File: rtl/xtrig_map.sv
module xtrig_map #(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CH   = 4
) (
  input  logic                             glb_en,
  input  logic [NUM_TRIG-1:0]              trig_in,
  input  logic [NUM_CH-1:0]                ch_in,
  input  logic [NUM_CH-1:0]                app_pulse,
  input  logic [NUM_TRIG-1:0][NUM_CH-1:0]  in_map,
  input  logic [NUM_TRIG-1:0][NUM_CH-1:0]  out_map,
  output logic [NUM_CH-1:0]                local_ch,
  output logic [NUM_TRIG-1:0]              trig_raw
);

  logic [NUM_CH-1:0] gathered;
  logic [NUM_CH-1:0] chan_evt;

  // Triggers onto channels
  always_comb begin
    gathered = app_pulse;
    for (int i = 0; i < NUM_TRIG; i++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        gathered[c] = gathered[c] | (trig_in[i] & in_map[i][c]);
      end
    end
    local_ch = glb_en ? gathered : '0;
  end

  // Channels seen by the output side: fabric plus own contribution
  assign chan_evt = ch_in | local_ch;

  // Channels onto triggers
  always_comb begin
    for (int j = 0; j < NUM_TRIG; j++) begin
      trig_raw[j] = glb_en & (|(chan_evt & out_map[j]));
    end
  end

endmodule

// File: rtl/xtrig_outstage.sv
module xtrig_outstage
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_raw,
  input  logic                core_halted,
  input  logic                ack_halt,
  input  logic                ack_irq,
  input  logic                irq_level,
  output logic [NUM_TRIG-1:0] trig_out
);

  for (genvar j = 0; j < NUM_TRIG; j++) begin : g_slot
    logic slot_q;
    logic slot_d;

    if (trig_kind(j) == TK_HALT) begin : g_halt
      // sticky; a new event beats a same-cycle acknowledge
      always_comb slot_d = (slot_q & ~ack_halt) | trig_raw[j];
    end else if (trig_kind(j) == TK_RESTART) begin : g_restart
      // delivered only to a halted core, never held
      always_comb slot_d = trig_raw[j] & core_halted;
    end else if (trig_kind(j) == TK_IRQ) begin : g_irq
      always_comb begin
        if (irq_level) begin
          slot_d = (slot_q & ~ack_irq) | trig_raw[j];
        end else begin
          slot_d = trig_raw[j];
        end
      end
    end else if (trig_kind(j) == TK_RESERVED) begin : g_rsvd
      logic unused_raw;
      assign unused_raw = trig_raw[j];
      always_comb slot_d = 1'b0;
    end else begin : g_selfclr
      always_comb slot_d = trig_raw[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= 1'b0;
      end else begin
        slot_q <= slot_d;
      end
    end

    assign trig_out[j] = slot_q;
  end

endmodule

// File: rtl/xtrig_iface.sv
module xtrig_iface
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CH   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                core_halted,
  input  logic [NUM_CH-1:0]   ch_in,
  output logic [NUM_TRIG-1:0] trig_out,
  output logic [NUM_CH-1:0]   ch_out,
  input  logic                wr_en,
  input  logic [6:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [6:0]          rd_addr,
  output logic [31:0]         rd_data
);

  ctrl_t                            ctrl;
  logic                             glb_en;
  logic                             irq_level;
  logic                             ack_halt;
  logic                             ack_irq;
  logic [NUM_CH-1:0]                app_pulse;
  logic [NUM_TRIG-1:0][NUM_CH-1:0]  in_map;
  logic [NUM_TRIG-1:0][NUM_CH-1:0]  out_map;
  logic [NUM_CH-1:0]                local_ch;
  logic [NUM_TRIG-1:0]              trig_raw;
  logic [NUM_CH-1:0]                ch_q;

  assign glb_en    = ctrl.en;
  assign irq_level = ctrl.irq_level;

  xtrig_regs #(.NUM_TRIG(NUM_TRIG), .NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .trig_live (trig_in),
    .ch_live   (ch_in),
    .ctrl      (ctrl),
    .ack_halt  (ack_halt),
    .ack_irq   (ack_irq),
    .app_pulse (app_pulse),
    .in_map    (in_map),
    .out_map   (out_map)
  );

  xtrig_map #(.NUM_TRIG(NUM_TRIG), .NUM_CH(NUM_CH)) u_map (
    .glb_en    (glb_en),
    .trig_in   (trig_in),
    .ch_in     (ch_in),
    .app_pulse (app_pulse),
    .in_map    (in_map),
    .out_map   (out_map),
    .local_ch  (local_ch),
    .trig_raw  (trig_raw)
  );

  xtrig_outstage #(.NUM_TRIG(NUM_TRIG)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_raw    (trig_raw),
    .core_halted (core_halted),
    .ack_halt    (ack_halt),
    .ack_irq     (ack_irq),
    .irq_level   (irq_level),
    .trig_out    (trig_out)
  );

  // Channel outputs registered toward the fabric
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else begin
      ch_q <= local_ch;
    end
  end

  assign ch_out = ch_q;

endmodule

// File: rtl/xtrig_iface_chk.sv
module xtrig_iface_chk
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CH   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TRIG-1:0] trig_out,
  input logic [NUM_CH-1:0]   ch_out,
  input logic                core_halted,
  input logic                wr_en,
  input logic [6:0]          wr_addr,
  input logic [31:0]         wr_data,
  input logic                glb_en,
  input logic                irq_level,
  input logic [NUM_TRIG-1:0] trig_raw
);

  logic halt_ack_wr;
  assign halt_ack_wr = wr_en && (wr_addr == RA_ACK) && wr_data[ACK_HALT_BIT];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (trig_out == '0 && ch_out == '0)); // R1

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out[0] && !halt_ack_wr) |=> trig_out[0]); // R5

  AST_RESTART_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out[1] |-> $past(core_halted)); // R6

  AST_IRQ_PULSE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq_level) && trig_out[2]) |-> $past(trig_raw[2])); // R7

  AST_CH_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glb_en) |-> (ch_out == '0)); // R9

endmodule

bind xtrig_iface xtrig_iface_chk #(.NUM_TRIG(NUM_TRIG), .NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_out    (trig_out),
  .ch_out      (ch_out),
  .core_halted (core_halted),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .glb_en      (glb_en),
  .irq_level   (irq_level),
  .trig_raw    (trig_raw)
);

// File: tb/tb_xtrig_iface.sv
`timescale 1ns/1ps
module tb_xtrig_iface;

  localparam int NUM_TRIG = 8;
  localparam int NUM_CH   = 4;

  logic                clk;
  logic                rst_n;
  logic [NUM_TRIG-1:0] trig_in;
  logic                core_halted;
  logic [NUM_CH-1:0]   ch_in;
  logic [NUM_TRIG-1:0] trig_out;
  logic [NUM_CH-1:0]   ch_out;
  logic                wr_en;
  logic [6:0]          wr_addr;
  logic [31:0]         wr_data;
  logic [6:0]          rd_addr;
  logic [31:0]         rd_data;

  xtrig_iface #(.NUM_TRIG(NUM_TRIG), .NUM_CH(NUM_CH)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .core_halted(core_halted),
    .ch_in(ch_in), .trig_out(trig_out), .ch_out(ch_out), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Bench model state
  bit                              m_en;
  bit                              m_lvl;
  logic [NUM_TRIG-1:0][NUM_CH-1:0] m_in;
  logic [NUM_TRIG-1:0][NUM_CH-1:0] m_outm;
  logic [NUM_TRIG-1:0]             m_trig;
  logic [NUM_CH-1:0]               m_ch;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic string req_of(input int j);
    case (j)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R4";
    endcase
  endfunction

  // Advance one clock: model next state from the driven inputs, then compare.
  task automatic step();
    logic [NUM_CH-1:0]   app, loc, evt;
    logic [NUM_TRIG-1:0] raw, nt;
    bit ah, ai;
    app = (wr_en && wr_addr == 7'd2) ? wr_data[NUM_CH-1:0] : '0;
    ah  = wr_en && wr_addr == 7'd1 && wr_data[0];
    ai  = wr_en && wr_addr == 7'd1 && wr_data[2];
    loc = app;
    for (int i = 0; i < NUM_TRIG; i++)
      for (int c = 0; c < NUM_CH; c++)
        if (trig_in[i] && m_in[i][c]) loc[c] = 1'b1;
    if (!m_en) loc = '0;
    evt = ch_in | loc;
    for (int j = 0; j < NUM_TRIG; j++) raw[j] = m_en && (|(evt & m_outm[j]));
    for (int j = 0; j < NUM_TRIG; j++) begin
      case (j)
        0: nt[j] = (m_trig[j] & ~ah) | raw[j];
        1: nt[j] = raw[j] & core_halted;
        2: nt[j] = m_lvl ? ((m_trig[j] & ~ai) | raw[j]) : raw[j];
        3: nt[j] = 1'b0;
        default: nt[j] = raw[j];
      endcase
    end
    m_trig = nt;
    m_ch   = loc;
    if (wr_en) begin
      if (wr_addr == 7'd0) begin
        m_en  = wr_data[0];
        m_lvl = wr_data[1];
      end
      if (wr_addr >= 7'd32 && int'(wr_addr) < 32 + NUM_TRIG) m_in[int'(wr_addr) - 32] = wr_data[NUM_CH-1:0];
      if (wr_addr >= 7'd64 && int'(wr_addr) < 64 + NUM_TRIG) m_outm[int'(wr_addr) - 64] = wr_data[NUM_CH-1:0];
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    for (int j = 0; j < NUM_TRIG; j++)
      check(trig_out[j] === m_trig[j], req_of(j), 32'(trig_out[j]), 32'(m_trig[j]));
    check(ch_out === m_ch, "R2", 32'(ch_out), 32'(m_ch));
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic rd_check(input logic [6:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    check(rd_data === exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = 0; m_lvl = 0; m_in = '0; m_outm = '0; m_trig = '0; m_ch = '0;
    rst_n = 1'b0; trig_in = '0; core_halted = 1'b0; ch_in = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(trig_out === '0, "R1 trig_out", 32'(trig_out), 0);
    check(ch_out === '0, "R1 ch_out", 32'(ch_out), 0);
    rd_check(7'd0, 0, "R1 ctrl");
    rd_check(7'd32, 0, "R1 inmap");
    rd_check(7'd64, 0, "R1 outmap");
    // R11: identity word
    rd_check(7'd5, (32'(NUM_TRIG) << 8) | 32'(NUM_CH), "R11 id");

    // R9: maps programmed but block disabled
    wr(7'd32, 32'h1);   // trigger 0 -> channel 0
    wr(7'd64, 32'h1);   // channel 0 -> halt output
    wr(7'd68, 32'h1);   // channel 0 -> output 4
    trig_in = 8'h01;
    step(); step();
    check(ch_out === '0, "R9 ch_out disabled", 32'(ch_out), 0);
    check(trig_out === '0, "R9 trig_out disabled", 32'(trig_out), 0);
    // R10: live status regardless of enable
    trig_in = 8'hA5; ch_in = 4'b1010;
    rd_check(7'd3, 32'hA5, "R10 trig status");
    rd_check(7'd4, 32'hA, "R10 chan status");
    ch_in = '0; trig_in = '0;
    step();

    // R2/R4/R5: enable and fire trigger 0
    wr(7'd0, 32'h1);
    trig_in = 8'h01;
    step();
    check(ch_out === 4'b0001, "R2 ch0 raised", 32'(ch_out), 1);
    check(trig_out[4] === 1'b1, "R4 out4 raised", 32'(trig_out[4]), 1);
    check(trig_out[0] === 1'b1, "R5 halt raised", 32'(trig_out[0]), 1);
    trig_in = '0;
    core_halted = 1'b1;
    step(); step();
    check(trig_out[4] === 1'b0, "R4 out4 cleared", 32'(trig_out[4]), 0);
    check(trig_out[0] === 1'b1, "R5 halt held", 32'(trig_out[0]), 1);
    // R5: acknowledge and new event in the same cycle: event wins
    trig_in = 8'h01;
    wr(7'd1, 32'h1);
    trig_in = '0;
    check(trig_out[0] === 1'b1, "R5 event beats ack", 32'(trig_out[0]), 1);
    wr(7'd1, 32'h1);
    check(trig_out[0] === 1'b0, "R5 ack clears", 32'(trig_out[0]), 0);

    // R6: restart gated by halted state and not remembered
    wr(7'd65, 32'h2);
    core_halted = 1'b0; ch_in = 4'b0010;
    step();
    check(trig_out[1] === 1'b0, "R6 dropped while running", 32'(trig_out[1]), 0);
    core_halted = 1'b1; ch_in = '0;
    step();
    check(trig_out[1] === 1'b0, "R6 not replayed", 32'(trig_out[1]), 0);
    ch_in = 4'b0010;
    step();
    check(trig_out[1] === 1'b1, "R6 delivered when halted", 32'(trig_out[1]), 1);
    ch_in = '0;
    step();
    check(trig_out[1] === 1'b0, "R6 self clears", 32'(trig_out[1]), 0);

    // R3/R7/R8: software channel pulse, interrupt pulse mode
    wr(7'd66, 32'h4);
    wr(7'd67, 32'hF);
    wr(7'd2, 32'h4);
    check(ch_out === 4'b0100, "R3 app pulse", 32'(ch_out), 4);
    check(trig_out[2] === 1'b1, "R7 pulse raised", 32'(trig_out[2]), 1);
    check(trig_out[3] === 1'b0, "R8 reserved low", 32'(trig_out[3]), 0);
    step();
    check(ch_out === 4'b0000, "R3 one cycle", 32'(ch_out), 0);
    check(trig_out[2] === 1'b0, "R7 pulse cleared", 32'(trig_out[2]), 0);
    // R7: level mode
    wr(7'd0, 32'h3);
    wr(7'd2, 32'h4);
    step(); step();
    check(trig_out[2] === 1'b1, "R7 level held", 32'(trig_out[2]), 1);
    wr(7'd1, 32'h4);
    check(trig_out[2] === 1'b0, "R7 level acked", 32'(trig_out[2]), 0);

    // Random phase, every cycle compared against the model
    for (int n = 0; n < 3000; n++) begin
      int sel;
      trig_in     = NUM_TRIG'($urandom & $urandom & $urandom);
      ch_in       = NUM_CH'($urandom & $urandom & $urandom);
      core_halted = $urandom_range(0, 1) == 1;
      sel = $urandom_range(0, 15);
      if (sel < 6) begin
        wr_en = 1'b1;
        case (sel)
          0: begin wr_addr = 7'd0; wr_data = ($urandom_range(0, 7) != 0) ? 32'(1 | ($urandom & 2)) : 0; end
          1: begin wr_addr = 7'd1; wr_data = $urandom & 32'h5; end
          2: begin wr_addr = 7'd2; wr_data = $urandom; end
          3: begin wr_addr = 7'(32 + $urandom_range(0, NUM_TRIG - 1)); wr_data = $urandom & $urandom; end
          default: begin wr_addr = 7'(64 + $urandom_range(0, NUM_TRIG - 1)); wr_data = $urandom & $urandom; end
        endcase
      end
      step();
    end

    report();
  end

endmodule